// File: doc/BRIEF.md
# Multiplexed-Bus Burst Write Sequencer

This block runs one synchronous burst write to an external memory that carries address and data on one shared bus. A single start pulse supplies the address, the burst length and a set of timing points. Each timing point is a count of functional-clock cycles measured from the first cycle of the access. The block then drives active-low chip select, address-valid and write-enable strobes and a direction flag. It places the address on the bus, then the data beats, which it pulls one at a time from a host-side valid/ready feed.

Timing uses an effective time `te`. Let `t` be the number of cycles since the access began. Let `A = max(accessTime,1)`, `P = max(pageTime,1)`, `N = beatsM1+1` and `F = (N-1)*P`. Then `te = t` for `t < A`, `te = A` for `A <= t <= A+F`, and `te = t-F` after that. Every strobe is a window on `te`, so its level is frozen while the later beats stream out. The access covers `F + max(cycleTime, A+1)` cycles. When it ends, the bus keeps its last value and does not float.

Top module: `admux_burst_wr`

## Requirements
- R1: After reset, and whenever the block is idle, csN, advN and weN are 1, dirOut, done and wrReady are 0, and busOut is 0 until the first access.
- R2: During an access, csN is 0 exactly when csOnTime <= te < csOffTime.
- R3: During an access, advN is 0 exactly when advOnTime <= te < advOffTime.
- R4: During an access, weN is 0 exactly when weOnTime <= te < weOffTime. This can include the address phase.
- R5: From t = 0, busOut carries the start address until t = D, where D is dataOnTime clamped into the range 1..A. At t = D the first beat appears on the bus, whatever the write-enable timing.
- R6: Beat k >= 1 appears at t = A + k*P. wrReady is 1 for exactly the one cycle before each beat appears, and a beat is taken only when wrValid is 1 in that cycle. If wrValid is 0, the bus keeps its previous value and that beat slot is spent.
- R7: In the F cycles with A <= t < A+F, csN, advN and weN do not change.
- R8: done is 1 only in the last cycle of the access, which is t = F + max(cycleTime, A+1) - 1. In the next cycle the block is idle.
- R9: dirOut is 1 in every cycle of an access and 0 otherwise.
- R10: While idle, busOut keeps the last value it drove.
- R11: A start while an access runs is ignored, and so are the address and length given with it. The running access completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an access when idle |
| startAddr | input | BUS_W | Address sent first on the bus |
| beatsM1 | input | 4 | Burst length minus one (1..16 beats) |
| csOnTime | input | 4 | Chip-select assert time |
| csOffTime | input | 5 | Chip-select release time |
| advOnTime | input | 4 | Address-valid assert time |
| advOffTime | input | 5 | Address-valid release time |
| weOnTime | input | 4 | Write-enable assert time |
| weOffTime | input | 5 | Write-enable release time |
| dataOnTime | input | 4 | First data beat launch time |
| accessTime | input | 5 | Time at which strobes freeze and beats stream |
| pageTime | input | 4 | Cycles each later beat stays on the bus |
| cycleTime | input | 5 | Total access length before burst stretch |
| wrData | input | BUS_W | Next data beat from host |
| wrValid | input | 1 | wrData holds a beat |
| wrReady | output | 1 | Block takes a beat this cycle |
| csN | output | 1 | Chip select, active low |
| advN | output | 1 | Address valid, active low |
| weN | output | 1 | Write enable, active low |
| dirOut | output | 1 | 1 while the bus is driven outward |
| busOut | output | BUS_W | Shared address/data bus |
| done | output | 1 | Last cycle of the access |

## Verification
The bench runs a four-beat burst with a two-cycle page and a long cycle time, so strobe release after the frozen span can be seen apart from the cycle-time end. A single-beat access with a cycle time below the access point checks the stretch rule with no freeze at all. Zero access, data-on and page times check each clamp. A burst with write enable low from time zero and one missing beat shows that data launch ignores the write-enable edge and that the bus holds on underrun. A sixteen-beat burst covers the widest beat counter, and a start pulse injected mid-access with other values shows that the latched setup is kept.

// File: rtl/admux_bw_pkg.sv
package admux_bw_pkg;
  localparam int ON_W   = 4;
  localparam int OFF_W  = 5;
  localparam int PAGE_W = 4;
  localparam int BEAT_W = 4;
  localparam int CNT_W  = OFF_W + 1;
  localparam int NUM_STROBES = 3;

  typedef struct packed {
    logic busy;
    logic csAct;
    logic advAct;
    logic weAct;
    logic loadAddr;
    logic loadBeat;
    logic done;
  } ctlStrobe_t;
endpackage

// File: rtl/admux_bw_window.sv
module admux_bw_window #(
  parameter int CW = 6,
  parameter int OW = 4,
  parameter int FW = 5
) (
  input  logic [CW-1:0] te,
  input  logic [OW-1:0] onT,
  input  logic [FW-1:0] offT,
  input  logic          en,
  output logic          act
);
  always_comb begin
    act = en && (te >= CW'(onT)) && (te < CW'(offT));
  end
endmodule

// File: rtl/admux_bw_ctrl.sv
module admux_bw_ctrl
  import admux_bw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BEAT_W-1:0] beatsM1,
  input  logic [ON_W-1:0]   csOnTime,
  input  logic [OFF_W-1:0]  csOffTime,
  input  logic [ON_W-1:0]   advOnTime,
  input  logic [OFF_W-1:0]  advOffTime,
  input  logic [ON_W-1:0]   weOnTime,
  input  logic [OFF_W-1:0]  weOffTime,
  input  logic [ON_W-1:0]   dataOnTime,
  input  logic [OFF_W-1:0]  accessTime,
  input  logic [PAGE_W-1:0] pageTime,
  input  logic [OFF_W-1:0]  cycleTime,
  input  logic              wrValid,
  output logic              wrReady,
  output ctlStrobe_t        strb
);
  // effective time, beat index on bus, page sub-counter
  logic              busy;
  logic [CNT_W-1:0]  te;
  logic [BEAT_W-1:0] beat;
  logic [PAGE_W-1:0] sub;

  // latched setup
  logic [NUM_STROBES-1:0][ON_W-1:0]  onQ;
  logic [NUM_STROBES-1:0][OFF_W-1:0] offQ;
  logic [BEAT_W-1:0] lastBeatQ;
  logic [CNT_W-1:0]  accQ, dataOnQ, endQ;
  logic [PAGE_W-1:0] pageQ;

  // clamped setup computed from the inputs
  logic [CNT_W-1:0]  accIn, dataOnIn, endIn;
  logic [PAGE_W-1:0] pageIn;

  always_comb begin
    accIn    = (accessTime == '0) ? CNT_W'(1) : CNT_W'(accessTime);
    dataOnIn = (dataOnTime == '0) ? CNT_W'(1) : CNT_W'(dataOnTime);
    if (dataOnIn > accIn) dataOnIn = accIn;
    pageIn   = (pageTime == '0) ? PAGE_W'(1) : pageTime;
    endIn    = (CNT_W'(cycleTime) > accIn) ? CNT_W'(cycleTime) : accIn + CNT_W'(1);
  end

  logic frozen, lastCyc, pageWrap, firstReq, accept;
  always_comb begin
    frozen   = busy && (te == accQ) && (beat != lastBeatQ);
    lastCyc  = busy && !frozen && (te == endQ - CNT_W'(1));
    pageWrap = (sub == pageQ - PAGE_W'(1));
    firstReq = busy && !frozen && (te == dataOnQ - CNT_W'(1));
    accept   = !busy && start;
    wrReady  = firstReq || (frozen && pageWrap);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      te        <= '0;
      beat      <= '0;
      sub       <= '0;
      onQ       <= '0;
      offQ      <= '0;
      lastBeatQ <= '0;
      accQ      <= CNT_W'(1);
      dataOnQ   <= CNT_W'(1);
      endQ      <= CNT_W'(2);
      pageQ     <= PAGE_W'(1);
    end else if (accept) begin
      busy      <= 1'b1;
      te        <= '0;
      beat      <= '0;
      sub       <= '0;
      onQ       <= {weOnTime, advOnTime, csOnTime};
      offQ      <= {weOffTime, advOffTime, csOffTime};
      lastBeatQ <= beatsM1;
      accQ      <= accIn;
      dataOnQ   <= dataOnIn;
      endQ      <= endIn;
      pageQ     <= pageIn;
    end else if (busy) begin
      if (lastCyc) begin
        busy <= 1'b0;
      end else if (frozen) begin
        if (pageWrap) begin
          sub  <= '0;
          beat <= beat + BEAT_W'(1);
        end else begin
          sub <= sub + PAGE_W'(1);
        end
      end else begin
        te <= te + CNT_W'(1);
      end
    end
  end

  // one comparator window per strobe
  logic [NUM_STROBES-1:0] actVec;
  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_win
    admux_bw_window #(.CW(CNT_W), .OW(ON_W), .FW(OFF_W)) u_win (
      .te  (te),
      .onT (onQ[g]),
      .offT(offQ[g]),
      .en  (busy),
      .act (actVec[g])
    );
  end

  always_comb begin
    strb.busy     = busy;
    strb.csAct    = actVec[0];
    strb.advAct   = actVec[1];
    strb.weAct    = actVec[2];
    strb.loadAddr = accept;
    strb.loadBeat = wrReady && wrValid;
    strb.done     = lastCyc;
  end

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    frozen |=> $stable(actVec)); // R7
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    lastCyc |=> !busy); // R8
  AST_TE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (te < endQ)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastCyc && start) |=> (busy && $stable(lastBeatQ) && $stable(accQ))); // R11
endmodule

// File: rtl/admux_bw_dpath.sv
module admux_bw_dpath
  import admux_bw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [BUS_W-1:0] startAddr,
  input  logic [BUS_W-1:0] wrData,
  output logic             csN,
  output logic             advN,
  output logic             weN,
  output logic             dirOut,
  output logic             done,
  output logic [BUS_W-1:0] busOut
);
  logic [BUS_W-1:0] busQ;

  // bus register doubles as the keeper when idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busQ <= '0;
    else if (strb.loadAddr) busQ <= startAddr;
    else if (strb.loadBeat) busQ <= wrData;
  end

  always_comb begin
    csN    = !strb.csAct;
    advN   = !strb.advAct;
    weN    = !strb.weAct;
    dirOut = strb.busy;
    done   = strb.done;
    busOut = busQ;
  end

  AST_IDLE_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy && !strb.loadAddr) |=> $stable(busQ)); // R10
  AST_BEAT_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBeat |-> strb.busy); // R6
endmodule

// File: rtl/admux_burst_wr.sv
module admux_burst_wr
  import admux_bw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BUS_W-1:0]  startAddr,
  input  logic [BEAT_W-1:0] beatsM1,
  input  logic [ON_W-1:0]   csOnTime,
  input  logic [OFF_W-1:0]  csOffTime,
  input  logic [ON_W-1:0]   advOnTime,
  input  logic [OFF_W-1:0]  advOffTime,
  input  logic [ON_W-1:0]   weOnTime,
  input  logic [OFF_W-1:0]  weOffTime,
  input  logic [ON_W-1:0]   dataOnTime,
  input  logic [OFF_W-1:0]  accessTime,
  input  logic [PAGE_W-1:0] pageTime,
  input  logic [OFF_W-1:0]  cycleTime,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic              csN,
  output logic              advN,
  output logic              weN,
  output logic              dirOut,
  output logic [BUS_W-1:0]  busOut,
  output logic              done
);
  ctlStrobe_t strb;

  admux_bw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .beatsM1(beatsM1),
    .csOnTime(csOnTime), .csOffTime(csOffTime),
    .advOnTime(advOnTime), .advOffTime(advOffTime),
    .weOnTime(weOnTime), .weOffTime(weOffTime),
    .dataOnTime(dataOnTime), .accessTime(accessTime),
    .pageTime(pageTime), .cycleTime(cycleTime),
    .wrValid(wrValid), .wrReady(wrReady), .strb(strb)
  );

  admux_bw_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .wrData(wrData), .csN(csN), .advN(advN), .weN(weN),
    .dirOut(dirOut), .done(done), .busOut(busOut)
  );

  AST_DIR_MATCHES_CS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> dirOut); // R9
endmodule

// File: tb/admux_burst_wr_tb.sv
module admux_burst_wr_tb;
  localparam int BUS_W = 16;
  localparam int MAXT  = 320;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [BUS_W-1:0] startAddr = '0;
  logic [3:0] beatsM1 = '0;
  logic [3:0] csOnT = '0, advOnT = '0, weOnT = '0, dataOnT = '0, pageT = '0;
  logic [4:0] csOffT = '0, advOffT = '0, weOffT = '0, accT = '0, cycT = '0;
  logic [BUS_W-1:0] wrData = '0;
  logic wrValid = 1'b0;
  logic wrReady, csN, advN, weN, dirOut, done;
  logic [BUS_W-1:0] busOut;

  int checks = 0;
  int failures = 0;
  logic [BUS_W-1:0] lastBus = '0;

  always #5 clk = ~clk;

  admux_burst_wr #(.BUS_W(BUS_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .beatsM1(beatsM1), .csOnTime(csOnT), .csOffTime(csOffT),
    .advOnTime(advOnT), .advOffTime(advOffT), .weOnTime(weOnT),
    .weOffTime(weOffT), .dataOnTime(dataOnT), .accessTime(accT),
    .pageTime(pageT), .cycleTime(cycT), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .csN(csN), .advN(advN), .weN(weN),
    .dirOut(dirOut), .busOut(busOut), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] beatVal(input int id, input int k);
    return BUS_W'(16'h5000 + id * 256 + k);
  endfunction

  task automatic idleCheck(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(csN == 1'b1 && advN == 1'b1 && weN == 1'b1, "R1 strobes idle", {csN, advN, weN}, 7);
      chk(dirOut == 1'b0 && done == 1'b0 && wrReady == 1'b0, "R1 flags idle",
          {dirOut, done, wrReady}, 0);
      chk(busOut == lastBus, "R10 bus kept", busOut, lastBus);
    end
  endtask

  // one access: reference model built from the requirements, compared each cycle
  task automatic runAccess(input int id, input logic [BUS_W-1:0] addr, input int nBeats,
                           input int cOn, input int cOff, input int aOn, input int aOff,
                           input int wOn, input int wOff, input int dOn, input int acc0,
                           input int pg0, input int cyc, input int drop, input int ignAt);
    logic expCs[MAXT], expAdv[MAXT], expWe[MAXT], expRdy[MAXT];
    logic [BUS_W-1:0] expBus[MAXT];
    int a, d, p, f, e, te, idx;
    logic [BUS_W-1:0] val;
    a = (acc0 == 0) ? 1 : acc0;
    d = (dOn == 0) ? 1 : dOn;
    if (d > a) d = a;
    p = (pg0 == 0) ? 1 : pg0;
    f = (nBeats - 1) * p;
    e = f + ((cyc > a) ? cyc : a + 1);
    val = addr;
    for (int t = 0; t < e; t++) begin
      te = (t < a) ? t : ((t <= a + f) ? a : t - f);
      expCs[t]  = (cOn <= te) && (te < cOff);
      expAdv[t] = (aOn <= te) && (te < aOff);
      expWe[t]  = (wOn <= te) && (te < wOff);
      if (t == d && drop != 0) val = beatVal(id, 0);
      if (t > a && t <= a + f && ((t - a) % p) == 0 && ((t - a) / p) != drop)
        val = beatVal(id, (t - a) / p);
      expBus[t] = val;
      expRdy[t] = (t == d - 1) || (t >= a && t < a + f && ((t - a) % p) == p - 1);
    end

    @(negedge clk);
    start = 1'b1; startAddr = addr; beatsM1 = 4'(nBeats - 1);
    csOnT = 4'(cOn); csOffT = 5'(cOff); advOnT = 4'(aOn); advOffT = 5'(aOff);
    weOnT = 4'(wOn); weOffT = 5'(wOff); dataOnT = 4'(dOn); accT = 5'(acc0);
    pageT = 4'(pg0); cycT = 5'(cyc);
    idx = 0;
    for (int t = 0; t < e; t++) begin
      @(negedge clk);
      start = (t == ignAt);
      startAddr = (t == ignAt) ? 16'hDEAD : addr;
      beatsM1 = (t == ignAt) ? 4'd0 : 4'(nBeats - 1);
      wrData = beatVal(id, idx);
      wrValid = (idx != drop);
      if (t >= a && t < a + f) begin
        chk({csN, advN, weN} == {!expCs[t], !expAdv[t], !expWe[t]}, "R7 frozen strobes",
            {csN, advN, weN}, {!expCs[t], !expAdv[t], !expWe[t]});
      end else begin
        chk(csN == !expCs[t], "R2 csN", csN, !expCs[t]);
        chk(advN == !expAdv[t], "R3 advN", advN, !expAdv[t]);
        chk(weN == !expWe[t], "R4 weN", weN, !expWe[t]);
      end
      if (t < d) chk(busOut == expBus[t], "R5 address phase", busOut, expBus[t]);
      else       chk(busOut == expBus[t], "R6 data beat", busOut, expBus[t]);
      chk(wrReady == expRdy[t], "R6 ready", wrReady, expRdy[t]);
      chk(dirOut == 1'b1, "R9 dir", dirOut, 1);
      chk(done == (t == e - 1), "R8 done", done, (t == e - 1));
      if (ignAt >= 0 && t > ignAt)
        chk(dirOut == 1'b1, "R11 start ignored", dirOut, 1);
      if (wrReady) idx++;
    end
    lastBus = expBus[e - 1];
    @(negedge clk);
    start = 1'b0; wrValid = 1'b0;
    chk(dirOut == 1'b0 && done == 1'b0, "R8 idle after done", {dirOut, done}, 0);
    idleCheck(3);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN && advN && weN && !dirOut && !done && !wrReady, "R1 reset outputs",
        {csN, advN, weN, dirOut, done, wrReady}, 6'b111000);
    chk(busOut == '0, "R1 reset bus", busOut, 0);
    rstN = 1'b1;
    idleCheck(2);
    // basic four-beat burst, mid-access start ignored (R11)
    runAccess(1, 16'h1234, 4, 1, 20, 0, 3, 2, 18, 3, 6, 2, 16, -1, 5);
    // single beat, cycle time stretched (R8)
    runAccess(2, 16'h0A0A, 1, 0, 4, 0, 2, 1, 4, 2, 5, 3, 3, -1, -1);
    // zero times clamp: access, data-on and page
    runAccess(3, 16'hBEEF, 3, 0, 6, 0, 1, 0, 5, 0, 0, 0, 2, -1, -1);
    // write enable low during address phase, beat 2 missing (R4, R5, R6)
    runAccess(4, 16'h4321, 4, 1, 12, 0, 2, 0, 10, 4, 7, 3, 9, 2, -1);
    // sixteen beats
    runAccess(5, 16'hC0DE, 16, 2, 31, 2, 4, 3, 25, 5, 8, 3, 20, -1, -1);
    // first beat missing: address stays on bus
    runAccess(6, 16'h7777, 2, 0, 9, 0, 2, 1, 8, 2, 4, 2, 6, 0, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule